// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block collects a parameterised set of maskable interrupt sources for a small 8-bit CPU, decides which of them is taken, and runs the CPU-side entry sequence for that source. Each source has a request flag held inside the block, plus a mask bit and a one-bit level bit supplied from configuration. The level bit is 0 for the high level and 1 for the low level. A global enable flag and an in-service level flag gate the sources. Ties at one level go to the lowest source index.

The CPU marks each instruction boundary with a strobe, and the block only considers a take on that strobe. When a source is taken, the block asserts an acknowledge and clears that source's flag. It then pushes the status word and the program counter onto the stack through a push port. Last, it asks the CPU to load the program counter with the source's vector. Low-level entries spend one extra cycle before the pushes begin. A return-from-interrupt strobe loads the popped program counter and restores the enable and in-service level flags.

Top module: `irq_vec_ctrl`

## Requirements
- R1: A pulse on `req_set_i[k]` sets request flag k (visible on `req_flags_o`). The flag stays set until source k is taken, so a pending request is taken at the first strobe where it is eligible.
- R2: A source is taken only when all of these hold in the same cycle: `boundary_i` is 1, its flag is 1, its mask bit is 0, the enable flag is 1, and no entry sequence is running. `ack_o` and `ack_id_o` report the take combinationally in that cycle.
- R3: While the in-service level flag is 0, sources whose level bit is 1 are not taken. Sources whose level bit is 0 still are.
- R4: Among eligible sources, a level-0 source beats a level-1 source. Within one level, the lowest index wins.
- R5: At the clock edge of a take, the winner's flag is cleared and all other flags are left unchanged. A `req_set_i` pulse to the winner in the same cycle wins over the clear.
- R6: The status word `psw_o` carries the enable flag at bit 7 and the in-service level flag at bit 1, with all other bits 0. At a take, enable becomes 0 and the in-service level becomes the winner's level bit.
- R7: `push_valid_o` is high for two consecutive cycles. The first carries the status word from the take cycle and the second carries `pc_i` from the take cycle. For a level-0 winner these are cycles take+1 and take+2. For a level-1 winner they are one cycle later.
- R8: In the cycle after the second push, `pc_load_o` is 1 and `pc_load_val_o` is `VEC_BASE + 2*index` (0x40 + 2*index by default).
- R9: `reti_i`, when no entry sequence is running, drives `pc_load_o` with `pop_pc_i` in the same cycle and loads enable and in-service level from `pop_ie_i` and `pop_isp_i` at the edge. No take happens in that cycle.
- R10: After reset all flags are 0, enable is 0, the in-service level is 1, and no sequence is running.
- R11: `ie_wr_i` loads the enable flag from `ie_val_i`. Both a take and a return in the same cycle override this write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_set_i | input | N_SRC | Request set pulses, one per source |
| mask_i | input | N_SRC | Mask bits, 1 blocks the source |
| prio_i | input | N_SRC | Level bits, 0 high, 1 low |
| boundary_i | input | 1 | Instruction-boundary strobe |
| pc_i | input | PC_W | Current program counter |
| ie_wr_i | input | 1 | Write strobe for the enable flag |
| ie_val_i | input | 1 | Value for the enable flag |
| reti_i | input | 1 | Return-from-interrupt strobe |
| pop_pc_i | input | PC_W | Program counter popped from the stack |
| pop_ie_i | input | 1 | Enable bit from the popped status word |
| pop_isp_i | input | 1 | In-service level bit from the popped status word |
| ack_o | output | 1 | Take acknowledge |
| ack_id_o | output | IDW | Index of the taken source |
| busy_o | output | 1 | Entry sequence running |
| push_valid_o | output | 1 | Stack push strobe |
| push_data_o | output | PC_W | Push data (status word zero-extended, then PC) |
| pc_load_o | output | 1 | Program counter load strobe |
| pc_load_val_o | output | PC_W | Program counter load value |
| psw_o | output | PSW_W | Current status word flags |
| req_flags_o | output | N_SRC | Request flags |

## Verification
Two events are driven into the same cycle on purpose. In the first, a take clears the winner's flag while a new set pulse arrives for that same source. In the second, the take also coincides with a software write to the enable flag. The bench does this by asserting `req_set_i` and `ie_wr_i` together with the boundary strobe. It then judges the result from the flag, which must stay set, and from `psw_o`, whose enable bit must read 0. A return with the strobe and an eligible source present is also checked: it must load the popped counter and suppress the acknowledge.

// File: rtl/irq_pkg.sv
package irq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_XTRA,
      ST_PSW,
      ST_PC,
      ST_VEC
   } seq_st_e;
endpackage

// File: rtl/irq_flags.sv
module irq_flags #(
   parameter int N_SRC = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] set_i,
   input  logic [N_SRC-1:0] clr_i,
   output logic [N_SRC-1:0] flags_o
);
   logic [N_SRC-1:0] flags_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (flags_q & ~clr_i) | set_i;
   end

   assign flags_o = flags_q;

   // a set pulse is never lost, even against a clear
   assert_set_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flags_o & $past(set_i)) == $past(set_i)));

   // untouched flags hold their value
   assert_pending_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flags_o & ~$past(set_i | clr_i)) ==
                ($past(flags_o) & ~$past(set_i | clr_i))));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
   parameter int N_SRC = 8,
   localparam int IDW = $clog2(N_SRC)
) (
   input  logic [N_SRC-1:0] req_i,
   input  logic [N_SRC-1:0] mask_i,
   input  logic [N_SRC-1:0] prio_i,
   input  logic             ie_i,
   input  logic             isp_i,
   output logic             any_o,
   output logic [IDW-1:0]   win_o,
   output logic             win_prio_o
);
   logic [N_SRC-1:0] elig;
   logic             hi_any, lo_any;
   logic [IDW-1:0]   hi_id, lo_id;

   for (genvar g = 0; g < N_SRC; g++) begin : g_elig
      assign elig[g] = req_i[g] & ~mask_i[g] & ie_i & (isp_i | ~prio_i[g]);
   end

   // descending scan: the last hit is the lowest index
   always_comb begin
      hi_any = 1'b0;
      lo_any = 1'b0;
      hi_id  = '0;
      lo_id  = '0;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (elig[i]) begin
            if (!prio_i[i]) begin
               hi_any = 1'b1;
               hi_id  = IDW'(i);
            end else begin
               lo_any = 1'b1;
               lo_id  = IDW'(i);
            end
         end
      end
   end

   assign any_o      = hi_any | lo_any;
   assign win_o      = hi_any ? hi_id : lo_id;
   assign win_prio_o = ~hi_any;
endmodule

// File: rtl/irq_seq.sv
module irq_seq
   import irq_pkg::*;
#(
   parameter int          N_SRC    = 8,
   parameter int          PC_W     = 16,
   parameter int          PSW_W    = 8,
   parameter logic [15:0] VEC_BASE = 16'h0040,
   localparam int IDW = $clog2(N_SRC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept_i,
   input  logic [IDW-1:0]   win_i,
   input  logic             win_prio_i,
   input  logic [PC_W-1:0]  pc_i,
   input  logic [PSW_W-1:0] psw_i,
   output logic             idle_o,
   output logic             push_valid_o,
   output logic [PC_W-1:0]  push_data_o,
   output logic             vec_load_o,
   output logic [PC_W-1:0]  vec_addr_o
);
   seq_st_e          st_q, st_d;
   logic [IDW-1:0]   id_q;
   logic [PSW_W-1:0] psw_q;
   logic [PC_W-1:0]  pc_q;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (accept_i) st_d = win_prio_i ? ST_XTRA : ST_PSW;
         ST_XTRA: st_d = ST_PSW;
         ST_PSW:  st_d = ST_PC;
         ST_PC:   st_d = ST_VEC;
         ST_VEC:  st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         id_q  <= '0;
         psw_q <= '0;
         pc_q  <= '0;
      end else begin
         st_q <= st_d;
         if (accept_i && st_q == ST_IDLE) begin
            id_q  <= win_i;
            psw_q <= psw_i;
            pc_q  <= pc_i;
         end
      end
   end

   assign idle_o       = (st_q == ST_IDLE);
   assign push_valid_o = (st_q == ST_PSW) || (st_q == ST_PC);
   assign push_data_o  = (st_q == ST_PSW) ? PC_W'(psw_q) : pc_q;
   assign vec_load_o   = (st_q == ST_VEC);
   assign vec_addr_o   = PC_W'(VEC_BASE) + (PC_W'(id_q) << 1);

   assert_psw_then_pc_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_PSW) |=> (st_q == ST_PC) && push_valid_o);
   assert_pc_then_vec_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_PC) |=> vec_load_o && !push_valid_o);
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
   parameter int          N_SRC    = 8,
   parameter int          PC_W     = 16,
   parameter int          PSW_W    = 8,
   parameter int          IE_BIT   = 7,
   parameter int          ISP_BIT  = 1,
   parameter logic [15:0] VEC_BASE = 16'h0040,
   localparam int IDW = $clog2(N_SRC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] req_set_i,
   input  logic [N_SRC-1:0] mask_i,
   input  logic [N_SRC-1:0] prio_i,
   input  logic             boundary_i,
   input  logic [PC_W-1:0]  pc_i,
   input  logic             ie_wr_i,
   input  logic             ie_val_i,
   input  logic             reti_i,
   input  logic [PC_W-1:0]  pop_pc_i,
   input  logic             pop_ie_i,
   input  logic             pop_isp_i,
   output logic             ack_o,
   output logic [IDW-1:0]   ack_id_o,
   output logic             busy_o,
   output logic             push_valid_o,
   output logic [PC_W-1:0]  push_data_o,
   output logic             pc_load_o,
   output logic [PC_W-1:0]  pc_load_val_o,
   output logic [PSW_W-1:0] psw_o,
   output logic [N_SRC-1:0] req_flags_o
);
   if (N_SRC < 2 || N_SRC > 64) begin : g_bad_n
      $error("irq_vec_ctrl: N_SRC must lie in 2..64");
   end
   if (IE_BIT == ISP_BIT || IE_BIT >= PSW_W || ISP_BIT >= PSW_W) begin : g_bad_bits
      $error("irq_vec_ctrl: flag bit positions invalid");
   end
   if (PC_W < PSW_W) begin : g_bad_pc
      $error("irq_vec_ctrl: PC_W must cover PSW_W");
   end

   logic             ie_q, isp_q;
   logic             any, win_prio, idle, accept, reti_ok;
   logic [IDW-1:0]   win;
   logic [N_SRC-1:0] clr;
   logic             vec_load;
   logic [PC_W-1:0]  vec_addr;

   irq_flags #(.N_SRC(N_SRC)) u_flags (
      .clk(clk), .rst_n(rst_n), .set_i(req_set_i), .clr_i(clr), .flags_o(req_flags_o)
   );

   irq_arbiter #(.N_SRC(N_SRC)) u_arb (
      .req_i(req_flags_o), .mask_i(mask_i), .prio_i(prio_i), .ie_i(ie_q), .isp_i(isp_q),
      .any_o(any), .win_o(win), .win_prio_o(win_prio)
   );

   assign accept  = idle & boundary_i & ~reti_i & any;
   assign reti_ok = idle & reti_i;

   always_comb begin
      clr = '0;
      if (accept) clr[win] = 1'b1;
   end

   always_comb begin
      psw_o          = '0;
      psw_o[IE_BIT]  = ie_q;
      psw_o[ISP_BIT] = isp_q;
   end

   irq_seq #(.N_SRC(N_SRC), .PC_W(PC_W), .PSW_W(PSW_W), .VEC_BASE(VEC_BASE)) u_seq (
      .clk(clk), .rst_n(rst_n), .accept_i(accept), .win_i(win), .win_prio_i(win_prio),
      .pc_i(pc_i), .psw_i(psw_o), .idle_o(idle), .push_valid_o(push_valid_o),
      .push_data_o(push_data_o), .vec_load_o(vec_load), .vec_addr_o(vec_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q  <= 1'b0;
         isp_q <= 1'b1;
      end else if (accept) begin
         ie_q  <= 1'b0;
         isp_q <= win_prio;
      end else if (reti_ok) begin
         ie_q  <= pop_ie_i;
         isp_q <= pop_isp_i;
      end else if (ie_wr_i) begin
         ie_q  <= ie_val_i;
      end
   end

   assign ack_o         = accept;
   assign ack_id_o      = win;
   assign busy_o        = ~idle;
   assign pc_load_o     = vec_load | reti_ok;
   assign pc_load_val_o = vec_load ? vec_addr : pop_pc_i;

   assert_take_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> req_flags_o[ack_id_o] && !mask_i[ack_id_o] && psw_o[IE_BIT]);
   assert_level_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o && !psw_o[ISP_BIT]) |-> !prio_i[ack_id_o]);
   assert_ie_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |=> !psw_o[IE_BIT] && busy_o && (psw_o[ISP_BIT] == $past(prio_i[ack_id_o])));
   assert_no_take_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !ack_o);
   assert_single_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({push_valid_o, pc_load_o}));
endmodule

// File: tb/irq_vec_ctrl_tb_top.sv
module irq_vec_ctrl_tb_top;
   // 250 MHz: 4 time units per period, read as ns
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  req_set_i = '0, mask_i = '0, prio_i = 8'h9F;
   logic        boundary_i = 0, ie_wr_i = 0, ie_val_i = 0, reti_i = 0;
   logic        pop_ie_i = 0, pop_isp_i = 0;
   logic [15:0] pc_i = '0, pop_pc_i = '0;
   logic        ack_o, busy_o, push_valid_o, pc_load_o;
   logic [2:0]  ack_id_o;
   logic [15:0] push_data_o, pc_load_val_o;
   logic [7:0]  psw_o, req_flags_o;

   always #2 clk = ~clk;

   irq_vec_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .req_set_i(req_set_i), .mask_i(mask_i), .prio_i(prio_i),
      .boundary_i(boundary_i), .pc_i(pc_i), .ie_wr_i(ie_wr_i), .ie_val_i(ie_val_i),
      .reti_i(reti_i), .pop_pc_i(pop_pc_i), .pop_ie_i(pop_ie_i), .pop_isp_i(pop_isp_i),
      .ack_o(ack_o), .ack_id_o(ack_id_o), .busy_o(busy_o), .push_valid_o(push_valid_o),
      .push_data_o(push_data_o), .pc_load_o(pc_load_o), .pc_load_val_o(pc_load_val_o),
      .psw_o(psw_o), .req_flags_o(req_flags_o)
   );

   typedef struct {
      bit          is_load;
      logic [15:0] data;
      int          cyc;
      string       req;
   } exp_t;

   exp_t exp_q[$];
   int   checks = 0, failures = 0, cyc = 0;
   bit   done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: pop and compare each push / load as it appears
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (push_valid_o || pc_load_o) begin
            if (exp_q.size() == 0) begin
               check(0, "R7", {15'd0, pc_load_o, push_data_o}, 32'hFFFF_FFFF);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check(pc_load_o == e.is_load, e.req, {31'd0, pc_load_o}, {31'd0, e.is_load});
               check((pc_load_o ? pc_load_val_o : push_data_o) == e.data, e.req,
                     {16'd0, pc_load_o ? pc_load_val_o : push_data_o}, {16'd0, e.data});
               check(cyc == e.cyc, e.req, cyc, e.cyc);
            end
         end
      end
   end

   // driver: strobe a take and queue the expected entry traffic
   task automatic take(input int id, input bit low, input logic [7:0] epsw,
                       input logic [15:0] epc, input logic [7:0] psw_after,
                       input logic [7:0] flags_after);
      exp_t e;
      pc_i       = epc;
      boundary_i = 1'b1;
      #1;
      check(ack_o == 1'b1, "R2", {31'd0, ack_o}, 1);
      check(ack_id_o == 3'(id), "R4", {29'd0, ack_id_o}, id);
      e.is_load = 0; e.data = {8'h00, epsw}; e.cyc = cyc + 1 + int'(low); e.req = "R7";
      exp_q.push_back(e);
      e.is_load = 0; e.data = epc; e.cyc = cyc + 2 + int'(low); e.req = "R7";
      exp_q.push_back(e);
      e.is_load = 1; e.data = 16'h0040 + 16'(2 * id); e.cyc = cyc + 3 + int'(low); e.req = "R8";
      exp_q.push_back(e);
      @(negedge clk);
      boundary_i = 0; req_set_i = '0; ie_wr_i = 0;
      #1;
      check(psw_o == psw_after, "R6", {24'd0, psw_o}, {24'd0, psw_after});
      check(req_flags_o == flags_after, "R5", {24'd0, req_flags_o}, {24'd0, flags_after});
      check(busy_o == 1'b1, "R7", {31'd0, busy_o}, 1);
      repeat (6) @(negedge clk);
   endtask

   initial begin
      #(4 * 200000);
      check(0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R10 reset state
      check(psw_o == 8'h02, "R10", {24'd0, psw_o}, 32'h02);
      check(req_flags_o == 8'h00, "R10", {24'd0, req_flags_o}, 0);
      check(busy_o == 0 && ack_o == 0, "R10", {30'd0, busy_o, ack_o}, 0);

      // R1 / R2: pending with enable off, then masked, then no strobe
      @(negedge clk); req_set_i = 8'h08;
      @(negedge clk); req_set_i = '0; boundary_i = 1;
      #1;
      check(ack_o == 0, "R2", {31'd0, ack_o}, 0);
      check(req_flags_o == 8'h08, "R1", {24'd0, req_flags_o}, 32'h08);
      @(negedge clk); boundary_i = 0; ie_wr_i = 1; ie_val_i = 1; mask_i = 8'h08;
      @(negedge clk); ie_wr_i = 0; boundary_i = 1;
      #1;
      check(psw_o == 8'h82, "R11", {24'd0, psw_o}, 32'h82);
      check(ack_o == 0, "R2", {31'd0, ack_o}, 0);
      @(negedge clk); boundary_i = 0; mask_i = '0;
      #1;
      check(ack_o == 0, "R2", {31'd0, ack_o}, 0);
      @(negedge clk);
      take(3, 1, 8'h82, 16'h0100, 8'h02, 8'h00);

      // R4: level 0 beats level 1, lowest index within level
      req_set_i = 8'h64; ie_wr_i = 1; ie_val_i = 1;
      @(negedge clk); req_set_i = '0; ie_wr_i = 0;
      take(5, 0, 8'h82, 16'h0200, 8'h00, 8'h44);

      // R3: low level blocked while in-service level is 0
      ie_wr_i = 1; ie_val_i = 1; mask_i = 8'h40;
      @(negedge clk); ie_wr_i = 0; boundary_i = 1;
      #1;
      check(ack_o == 0, "R3", {31'd0, ack_o}, 0);
      @(negedge clk); boundary_i = 0; mask_i = '0;
      take(6, 0, 8'h80, 16'h0300, 8'h00, 8'h04);

      // R9: return with strobe and pending source
      begin
         exp_t e;
         reti_i = 1; pop_ie_i = 1; pop_isp_i = 1; pop_pc_i = 16'h1234; boundary_i = 1;
         e.is_load = 1; e.data = 16'h1234; e.cyc = cyc; e.req = "R9";
         exp_q.push_back(e);
      end
      #1;
      check(ack_o == 0, "R9", {31'd0, ack_o}, 0);
      @(negedge clk); reti_i = 0; boundary_i = 0;
      #1;
      check(psw_o == 8'h82, "R9", {24'd0, psw_o}, 32'h82);

      // R5 / R11 collision: set pulse and enable write in the take cycle
      @(negedge clk);
      req_set_i = 8'h04; ie_wr_i = 1; ie_val_i = 1;
      take(2, 1, 8'h82, 16'h0400, 8'h02, 8'h04);

      repeat (10) @(negedge clk);
      check(exp_q.size() == 0, "R7", exp_q.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule